// File: doc/BRIEF.md
# Dimming-Off Drain Sense Fault Timer

This block catches a short between an LED string and chassis during the periods when the string is not being driven. That is the case while the dimming input is low, or when only the input supply is present. A timer starts when dimming goes low, or when the input-supply-valid signal first rises. It counts a fixed number of switching-cycle ticks. On the tick that ends the wait, the block samples a comparator that watches the drain of the string's disconnect switch. The drain should have been pulled up above the comparator threshold by then. A reading still below threshold at that moment is a wiring fault.

A fault raises a one-cycle fault request. That request, together with the fault from the companion detector that works while dimming is high, sets a single latched, active-low wiring-fault flag. The flag stays set until the input supply drops. Dimming returning high before the wait ends abandons that check, so an off-time shorter than the wait produces no check. The comparator arrives asynchronously and passes through a synchronizer. Its value counts only in the expiry cycle.

Top module: `drn_fault_timer`

## Requirements
- R1: After reset, `flag_n` is 1 and `fault_req` is 0.
- R2: A falling edge on `dim_in` (while `vin_ok` is 1) starts a wait. On the clock edge that samples the WAIT_CYCLES-th `sw_tick` pulse after the start, a synchronized drain reading of 0 (below threshold) makes `fault_req` 1 for exactly one cycle.
- R3: Only clock cycles with `sw_tick` = 1 advance the wait. `fault_req` stays 0 through the first WAIT_CYCLES-1 ticks after a start.
- R4: A rising edge on `vin_ok` while `dim_in` is 0 starts the same wait as R2. A reset released with `vin_ok` already 1 counts as such an edge.
- R5: A synchronized drain reading of 1 at expiry gives no fault request. Each start performs at most one check, so later ticks without a new start never raise `fault_req`.
- R6: While `dim_in` is 1 no wait runs and `fault_req` is 0 in the next cycle. A rising edge cancels a pending wait, and the next falling edge counts from zero again.
- R7: `drain_hi` reaches the check through a SYNC_STAGES-flop synchronizer. Only the value present SYNC_STAGES cycles before the expiry edge decides; earlier low readings are ignored.
- R8: `flag_n` goes to 0 one cycle after `fault_req` is 1. It then stays 0 while `vin_ok` is 1, whatever `dim_in`, `drain_hi` and `sw_tick` do.
- R9: `vin_ok` = 0 clears the flag (`flag_n` = 1 one cycle later) and abandons any wait. `fault_req` is 0 in the cycle after `vin_ok` is 0.
- R10: `high_fault` = 1 while `vin_ok` is 1 sets the same flag one cycle later, without asserting `fault_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vin_ok | input | 1 | Input supply valid; low clears the flag |
| dim_in | input | 1 | Dimming input, synchronous, 1 = string driven |
| sw_tick | input | 1 | One-cycle pulse per switching cycle |
| drain_hi | input | 1 | Asynchronous drain comparator, 1 = above threshold |
| high_fault | input | 1 | Fault from the dimming-high detector |
| fault_req | output | 1 | One-cycle wiring-fault request from this timer |
| flag_n | output | 1 | Latched wiring-fault flag, active low |

## Verification
The bench builds the block with WAIT_CYCLES = 5 and SYNC_STAGES = 2. A full wait therefore takes only five hand-driven tick pulses. This puts the exact expiry tick, the tick just before it, and a cancel-and-restart part way through a wait within a few dozen cycles. The short synchronizer lets the bench change the drain reading a few cycles before expiry and show that only the synchronized value at expiry decides. A supply drop landing on the expiry tick itself is also exercised.

// File: rtl/drn_pkg.sv
package drn_pkg;

    // Phase of the off-time wait timer.
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_WAIT = 1'b1
    } phase_e;

    // Command from the edge logic to the wait timer.
    typedef struct packed {
        logic start;   // begin a fresh wait at count zero
        logic cancel;  // abandon any wait (wins over start)
    } timer_cmd_t;

endpackage

// File: rtl/drn_sync.sv
module drn_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    typedef struct packed {
        logic [STAGES-1:0] chain;
    } sync_st_t;

    sync_st_t st_d, st_q;

    generate
        if (STAGES > 1) begin : g_multi
            always_comb begin
                st_d = st_q;
                st_d.chain = {st_q.chain[STAGES-2:0], din};
            end
        end else begin : g_single
            always_comb begin
                st_d = st_q;
                st_d.chain = din;
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q.chain[STAGES-1];

endmodule

// File: rtl/drn_wait_timer.sv
module drn_wait_timer
    import drn_pkg::*;
#(
    parameter int WAIT_CYCLES = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  timer_cmd_t cmd,
    input  logic       tick,
    output logic       expire,
    output logic       busy
);
    localparam int CW = (WAIT_CYCLES > 2) ? $clog2(WAIT_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(WAIT_CYCLES - 1);

    typedef struct packed {
        phase_e        ph;
        logic [CW-1:0] cnt;
    } tmr_st_t;

    tmr_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        expire = 1'b0;
        if (cmd.cancel) begin
            st_d.ph  = PH_IDLE;
            st_d.cnt = '0;
        end else if (cmd.start) begin
            st_d.ph  = PH_WAIT;
            st_d.cnt = '0;
        end else if (st_q.ph == PH_WAIT && tick) begin
            if (st_q.cnt == LAST) begin
                expire   = 1'b1;
                st_d.ph  = PH_IDLE;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_IDLE, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = (st_q.ph == PH_WAIT);

    // R3: the tick count never passes the last wait position
    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST);

    // R6: a cancel leaves the timer idle at count zero
    assert_cancel_idles_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd.cancel |=> (!busy && st_q.cnt == '0));

    // R5: an idle timer holds count zero until a new start
    assert_idle_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> st_q.cnt == '0);

endmodule

// File: rtl/drn_flag_latch.sv
module drn_flag_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic keep,     // input supply valid; low clears
    input  logic set_off,  // request from the dimming-off timer
    input  logic set_on,   // fault from the dimming-high detector
    output logic flag
);
    typedef struct packed {
        logic flag;
    } lat_st_t;

    lat_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!keep) begin
            st_d.flag = 1'b0;
        end else if (set_off || set_on) begin
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag = st_q.flag;

    // R8: a set with the supply valid shows up one cycle later
    assert_set_takes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (keep && (set_off || set_on)) |=> flag);

    // R8: once set, the flag holds while the supply stays valid
    assert_flag_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && keep) |=> flag);

    // R9: a supply drop clears the flag
    assert_supply_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !keep |=> !flag);

endmodule

// File: rtl/drn_fault_timer.sv
module drn_fault_timer
    import drn_pkg::*;
#(
    parameter int WAIT_CYCLES = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic vin_ok,
    input  logic dim_in,
    input  logic sw_tick,
    input  logic drain_hi,
    input  logic high_fault,
    output logic fault_req,
    output logic flag_n
);
    typedef struct packed {
        logic dim;
        logic vin;
        logic req;
    } top_st_t;

    top_st_t    st_d, st_q;
    timer_cmd_t cmd;
    logic       drain_s;
    logic       expire;
    logic       busy;
    logic       flag;

    drn_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (drain_hi),
        .dout  (drain_s)
    );

    drn_wait_timer #(.WAIT_CYCLES(WAIT_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmd    (cmd),
        .tick   (sw_tick),
        .expire (expire),
        .busy   (busy)
    );

    drn_flag_latch u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .keep    (vin_ok),
        .set_off (st_q.req),
        .set_on  (high_fault),
        .flag    (flag)
    );

    always_comb begin
        st_d       = st_q;
        st_d.dim   = dim_in;
        st_d.vin   = vin_ok;
        cmd.start  = (st_q.dim && !dim_in) || (vin_ok && !st_q.vin);
        cmd.cancel = dim_in || !vin_ok;
        st_d.req   = expire && !drain_s && vin_ok;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fault_req = st_q.req;
    assign flag_n    = ~flag;

    // R2: a request only follows a low synchronized drain reading
    assert_req_needs_low_drain_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fault_req |-> $past(!drain_s));

    // R2: a request is a single-cycle pulse
    assert_req_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fault_req |=> !fault_req);

    // R6: dimming high suppresses any request in the next cycle
    assert_dim_high_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dim_in |=> !fault_req);

    // R9: no request right after the input supply is lost
    assert_no_req_after_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !vin_ok |=> !fault_req);

    // R5: a request needs a running wait in the previous cycle
    assert_req_needs_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fault_req |-> $past(busy));

endmodule

// File: tb/sim_drn_fault_timer.sv
module sim_drn_fault_timer;
    localparam int WAIT = 5;
    localparam int SYNC = 2;
    localparam time PERIOD = 8ns;

    logic clk = 1'b0;
    logic rst_n, vin_ok, dim_in, sw_tick, drain_hi, high_fault;
    logic fault_req, flag_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(PERIOD / 2) clk = ~clk;

    drn_fault_timer #(.WAIT_CYCLES(WAIT), .SYNC_STAGES(SYNC)) u0 (
        .clk(clk), .rst_n(rst_n), .vin_ok(vin_ok), .dim_in(dim_in),
        .sw_tick(sw_tick), .drain_hi(drain_hi), .high_fault(high_fault),
        .fault_req(fault_req), .flag_n(flag_n)
    );

    task automatic check(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Ticks that must not end a wait; fault_req checked after each.
    task automatic quiet_ticks(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) sw_tick = 1'b1;
            @(negedge clk) sw_tick = 1'b0;
            check(fault_req, 1'b0, tag);
        end
    endtask

    task automatic one_tick();
        @(negedge clk) sw_tick = 1'b1;
        @(negedge clk) sw_tick = 1'b0;
    endtask

    task automatic clear_flag();
        @(negedge clk) dim_in = 1'b1;
        @(negedge clk) vin_ok = 1'b0;
        @(negedge clk) vin_ok = 1'b1;
        @(negedge clk);
    endtask

    task automatic dim_fall();
        @(negedge clk) dim_in = 1'b0;
    endtask

    task automatic t_reset_and_powerup();
        rst_n = 1'b0; vin_ok = 1'b0; dim_in = 1'b0; sw_tick = 1'b0;
        drain_hi = 1'b0; high_fault = 1'b0;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        check(flag_n, 1'b1, "R1 flag_n after reset");
        check(fault_req, 1'b0, "R1 fault_req after reset");
        vin_ok = 1'b1;                       // R4: power-up start
        idle(1);
        quiet_ticks(WAIT - 1, "R3 early tick after power-up");
        one_tick();
        check(fault_req, 1'b1, "R4 power-up expiry request");
        idle(1);
        check(fault_req, 1'b0, "R2 request lasts one cycle");
        check(flag_n, 1'b0, "R8 flag set after request");
    endtask

    task automatic t_flag_hold_and_clear();
        dim_in = 1'b1; drain_hi = 1'b1;
        quiet_ticks(3, "R6 no request while dim high");
        dim_in = 1'b0;
        quiet_ticks(2, "R8 hold quiet");
        dim_in = 1'b1;
        idle(1);
        check(flag_n, 1'b0, "R8 flag holds while supply valid");
        vin_ok = 1'b0;
        idle(1);
        check(flag_n, 1'b1, "R9 supply drop clears flag");
        vin_ok = 1'b1;
        idle(1);
    endtask

    task automatic t_dim_fall_fault();
        drain_hi = 1'b0;
        dim_fall();
        quiet_ticks(WAIT - 1, "R3 early tick after dim fall");
        one_tick();
        check(fault_req, 1'b1, "R2 dim-fall expiry request");
        idle(1);
        check(flag_n, 1'b0, "R8 flag after dim-fall request");
        clear_flag();
    endtask

    task automatic t_drain_ok_one_shot();
        drain_hi = 1'b1;
        dim_fall();
        quiet_ticks(WAIT, "R5 drain high gives no request");
        drain_hi = 1'b0;
        idle(SYNC + 1);
        quiet_ticks(WAIT + 1, "R5 no second check without new start");
        check(flag_n, 1'b1, "R5 flag stays clear");
    endtask

    task automatic t_cancel_restart();
        dim_in = 1'b1;
        idle(1);
        drain_hi = 1'b0;
        dim_fall();
        quiet_ticks(3, "R6 ticks before cancel");
        @(negedge clk) dim_in = 1'b1;
        @(negedge clk) dim_in = 1'b0;         // restart from zero
        quiet_ticks(WAIT - 1, "R6 restart counts from zero");
        one_tick();
        check(fault_req, 1'b1, "R6 expiry after restart");
        idle(1);
        clear_flag();
    endtask

    task automatic t_sync_window();
        drain_hi = 1'b0;
        dim_fall();
        quiet_ticks(WAIT - 1, "R7 early ticks");
        drain_hi = 1'b1;
        idle(SYNC + 1);
        one_tick();
        check(fault_req, 1'b0, "R7 late high reading wins");
        idle(1);
        check(flag_n, 1'b1, "R7 flag clear after late high");
        @(negedge clk) dim_in = 1'b1;
        dim_fall();
        quiet_ticks(WAIT - 1, "R7 early ticks second pass");
        drain_hi = 1'b0;
        idle(SYNC + 1);
        one_tick();
        check(fault_req, 1'b1, "R7 late low reading flagged");
        idle(1);
        clear_flag();
        drain_hi = 1'b1;
    endtask

    task automatic t_supply_drop();
        dim_in = 1'b1;
        idle(1);
        drain_hi = 1'b0;
        dim_fall();
        quiet_ticks(WAIT - 1, "R9 ticks before drop");
        @(negedge clk) begin vin_ok = 1'b0; sw_tick = 1'b1; end
        @(negedge clk) begin sw_tick = 1'b0; dim_in = 1'b1; end
        check(fault_req, 1'b0, "R9 no request on drop cycle");
        idle(1);
        check(flag_n, 1'b1, "R9 flag clear after drop");
        vin_ok = 1'b1;
        idle(1);
        dim_in = 1'b0;                        // while vin already up: dim-fall start
        idle(1);
        quiet_ticks(WAIT - 1, "R9 wait restarted after drop");
        one_tick();
        check(fault_req, 1'b1, "R9 expiry after restart");
        idle(1);
        clear_flag();
    endtask

    task automatic t_high_fault();
        drain_hi = 1'b1;
        @(negedge clk) high_fault = 1'b1;
        @(negedge clk) high_fault = 1'b0;
        check(flag_n, 1'b0, "R10 high-side fault sets flag");
        check(fault_req, 1'b0, "R10 no timer request");
        idle(2);
        check(flag_n, 1'b0, "R10 flag holds");
        clear_flag();
        check(flag_n, 1'b1, "R10 flag cleared by supply drop");
    endtask

    initial begin
        t_reset_and_powerup();
        t_flag_hold_and_clear();
        t_dim_fall_fault();
        t_drain_ok_one_shot();
        t_cancel_restart();
        t_sync_window();
        t_supply_drop();
        t_high_fault();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule